// File: doc/BRIEF.md
# Bus-Master Disk DMA Control and Status Registers

This block is the register file that software sees for one bus-master disk DMA channel. It holds three registers. The first is a control byte that starts and stops the transfer and sets its direction. The second is a status byte. The third is a 32-bit pointer to the descriptor table in memory. Software reaches them over a simple word-wide register bus with byte lanes. The block passes the start and direction controls to the transfer engine. From that engine it takes a busy level and one-cycle pulses for error and completion events.

The status byte holds three kinds of bits:
- Sticky completion and error flags. Each one latches on its engine event, and software clears it by writing a one to it.
- A busy flag that follows the engine only while the channel is started.
- Two per-drive "DMA capable" bits that software owns.

The block also computes a good-completion indication: the completion flag is set, and both the busy and the error flags are clear.

Top module: `bm_dma_regs`

## Requirements
- R1: After synchronous reset, every register bit, `start`, `dir_to_mem`, `irq` and `cpl_ok` is 0.
- R2: A write to byte address 0 with byte enable 0 stores the control byte. Bit 0 is start and drives `start`. Bit 3 is direction and drives `dir_to_mem`; a 1 means the device writes to memory. Both outputs change on the clock edge of the write. All other control bits read as 0.
- R3: A control write that arrives while start is already set leaves the direction bit unchanged. Start itself still takes the written value.
- R4: Status bit 0 (busy) equals the engine `eng_busy` input registered under the start value that takes effect on the same edge. It is 0 from the edge at which start is cleared.
- R5: An `eng_err_evt` pulse sets status bit 1 (error). An `eng_int_evt` pulse sets status bit 2 (completion). Each flag holds until software clears it.
- R6: A write to byte address 2 with byte enable 2 clears bit 1 and/or bit 2 wherever the written bit is 1. A 0 leaves the bit alone. Writing back a status value read with both flags set clears both. An event in the same cycle as a clear wins.
- R7: Status bits 5 and 6 are read/write capability flags for drive 0 and drive 1. They keep their value across every flag change. Bits 3, 4 and 7 read as 0.
- R8: `irq` is 1 exactly while the completion flag is set.
- R9: `cpl_ok` is 1 exactly when the completion flag is set and both the busy and the error flags are clear.
- R10: The word at byte address 4 is the descriptor-table pointer. It is written per byte lane under `bus_be`, bits 1:0 always read 0, and `tbl_ptr` carries its value.
- R11: A read returns data on `bus_rdata` one cycle after `bus_rd`. Word 0 carries the control byte in bits 7:0 and the status byte in bits 23:16, with all other bits 0. Word 1 carries the pointer. A write with no byte enable set changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Byte address; bit 2 selects the word |
| bus_be | input | 4 | Byte lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| eng_busy | input | 1 | Engine transfer-in-progress level |
| eng_err_evt | input | 1 | One-cycle engine error event |
| eng_int_evt | input | 1 | One-cycle engine completion event |
| start | output | 1 | Run control to the engine |
| dir_to_mem | output | 1 | Direction: 1 means device-to-memory |
| irq | output | 1 | Interrupt request, follows the completion flag |
| cpl_ok | output | 1 | Good-completion indication |
| tbl_ptr | output | 32 | Descriptor-table physical address |

## Verification
The hardest case to reach from the ports is a software clear of the completion flag that lands on the same edge as a new completion event. The bench lines up a status write and an `eng_int_evt` pulse on one negative edge, so that both are sampled together, and then checks that the flag survives. Two other cases are set up in the same way. A direction change is written while start is already set, which checks the lock. Busy is dropped and raised with start held, and then start is cleared while the engine is still busy.

// File: rtl/bm_regs_pkg.sv
package bm_regs_pkg;
  // control byte bit positions
  localparam int CTL_START = 0;
  localparam int CTL_DIR   = 3;
  // status byte bit positions
  localparam int ST_ACT    = 0;
  localparam int ST_ERR    = 1;
  localparam int ST_INT    = 2;
  localparam int ST_CAP_LO = 5;
  localparam int NUM_DRV   = 2;
  // byte lanes inside word 0
  localparam int LANE_CTL  = 0;
  localparam int LANE_ST   = 2;
endpackage

// File: rtl/bmr_ctl_reg.sv
module bmr_ctl_reg
  import bm_regs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic       start_q,
  output logic       dir_q,
  output logic       start_nxt,
  output logic [7:0] ctl_byte
);
  always_comb start_nxt = wr ? wdata[CTL_START] : start_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= 1'b0;
      dir_q   <= 1'b0;
    end else begin
      start_q <= start_nxt;
      // direction may only change while the channel is stopped
      if (wr && !start_q) dir_q <= wdata[CTL_DIR];
    end
  end

  always_comb begin
    ctl_byte = '0;
    ctl_byte[CTL_START] = start_q;
    ctl_byte[CTL_DIR]   = dir_q;
  end
endmodule

// File: rtl/bmr_stat_reg.sv
module bmr_stat_reg
  import bm_regs_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               wr,
  input  logic [7:0]         wdata,
  input  logic               start_nxt,
  input  logic               busy,
  input  logic               err_evt,
  input  logic               int_evt,
  output logic               act_f,
  output logic               err_f,
  output logic               int_f,
  output logic [NUM_DRV-1:0] cap_f,
  output logic [7:0]         stat_byte
);
  logic clr_err, clr_int;
  always_comb begin
    clr_err = wr && wdata[ST_ERR];
    clr_int = wr && wdata[ST_INT];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_f <= 1'b0;
      err_f <= 1'b0;
      int_f <= 1'b0;
      cap_f <= '0;
    end else begin
      act_f <= start_nxt && busy;
      // a new event outranks a simultaneous software clear
      err_f <= err_evt || (err_f && !clr_err);
      int_f <= int_evt || (int_f && !clr_int);
      if (wr) cap_f <= wdata[ST_CAP_LO +: NUM_DRV];
    end
  end

  always_comb begin
    stat_byte = '0;
    stat_byte[ST_ACT] = act_f;
    stat_byte[ST_ERR] = err_f;
    stat_byte[ST_INT] = int_f;
    stat_byte[ST_CAP_LO +: NUM_DRV] = cap_f;
  end
endmodule

// File: rtl/bmr_ptr_reg.sv
module bmr_ptr_reg #(
  parameter int PTR_W   = 32,
  parameter int ALIGN_B = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr,
  input  logic [PTR_W/8-1:0] be,
  input  logic [PTR_W-1:0]   wdata,
  output logic [PTR_W-1:0]   ptr_q
);
  localparam int LANES = PTR_W / 8;
  logic [PTR_W-1:0] raw_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) raw_q[g*8 +: 8] <= '0;
      else if (wr && be[g]) raw_q[g*8 +: 8] <= wdata[g*8 +: 8];
    end
  end

  always_comb begin
    ptr_q = raw_q;
    ptr_q[ALIGN_B-1:0] = '0;
  end
endmodule

// File: rtl/bm_dma_regs.sv
module bm_dma_regs
  import bm_regs_pkg::*;
#(
  parameter int DW      = 32,
  parameter int AW      = 3,
  parameter int ALIGN_B = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW/8-1:0] bus_be,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          eng_busy,
  input  logic          eng_err_evt,
  input  logic          eng_int_evt,
  output logic          start,
  output logic          dir_to_mem,
  output logic          irq,
  output logic          cpl_ok,
  output logic [DW-1:0] tbl_ptr
);
  localparam int WSEL = 2;

  logic sel_w1, ctl_wr, stat_wr, ptr_wr;
  logic start_nxt;
  logic [7:0] ctl_byte, stat_byte;
  logic act_f, err_f, int_f;
  logic [NUM_DRV-1:0] cap_f;
  logic [DW-1:0] word0;

  always_comb begin
    sel_w1  = bus_addr[WSEL];
    ctl_wr  = bus_wr && !sel_w1 && bus_be[LANE_CTL];
    stat_wr = bus_wr && !sel_w1 && bus_be[LANE_ST];
    ptr_wr  = bus_wr && sel_w1;
  end

  bmr_ctl_reg u_ctl (
    .clk(clk), .rst(rst), .wr(ctl_wr), .wdata(bus_wdata[LANE_CTL*8 +: 8]),
    .start_q(start), .dir_q(dir_to_mem), .start_nxt(start_nxt), .ctl_byte(ctl_byte)
  );

  bmr_stat_reg u_stat (
    .clk(clk), .rst(rst), .wr(stat_wr), .wdata(bus_wdata[LANE_ST*8 +: 8]),
    .start_nxt(start_nxt), .busy(eng_busy), .err_evt(eng_err_evt),
    .int_evt(eng_int_evt), .act_f(act_f), .err_f(err_f), .int_f(int_f),
    .cap_f(cap_f), .stat_byte(stat_byte)
  );

  bmr_ptr_reg #(.PTR_W(DW), .ALIGN_B(ALIGN_B)) u_ptr (
    .clk(clk), .rst(rst), .wr(ptr_wr), .be(bus_be), .wdata(bus_wdata), .ptr_q(tbl_ptr)
  );

  always_comb begin
    word0 = '0;
    word0[LANE_CTL*8 +: 8] = ctl_byte;
    word0[LANE_ST*8 +: 8]  = stat_byte;
    irq    = int_f;
    cpl_ok = int_f && !act_f && !err_f;
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= sel_w1 ? tbl_ptr : word0;
  end
endmodule

// File: rtl/bm_dma_regs_chk.sv
module bm_dma_regs_chk (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       dir_to_mem,
  input logic       act_f,
  input logic       err_f,
  input logic       int_f,
  input logic       irq,
  input logic       ctl_wr,
  input logic       stat_wr,
  input logic [7:0] stat_wdata,
  input logic       eng_err_evt,
  input logic       eng_int_evt
);
  assert_dir_locked_R3: assert property (@(posedge clk) disable iff (rst)
    (start && ctl_wr) |=> $stable(dir_to_mem));
  assert_act_gated_R4: assert property (@(posedge clk) disable iff (rst)
    !start |-> !act_f);
  assert_int_latch_R5: assert property (@(posedge clk) disable iff (rst)
    eng_int_evt |=> int_f);
  assert_err_latch_R5: assert property (@(posedge clk) disable iff (rst)
    eng_err_evt |=> err_f);
  assert_int_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (stat_wr && stat_wdata[2] && !eng_int_evt) |=> !int_f);
  assert_irq_source_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(eng_int_evt));
endmodule

bind bm_dma_regs bm_dma_regs_chk u_chk (
  .clk(clk), .rst(rst), .start(start), .dir_to_mem(dir_to_mem),
  .act_f(act_f), .err_f(err_f), .int_f(int_f), .irq(irq),
  .ctl_wr(ctl_wr), .stat_wr(stat_wr), .stat_wdata(bus_wdata[23:16]),
  .eng_err_evt(eng_err_evt), .eng_int_evt(eng_int_evt)
);

// File: tb/test_bm_dma_regs.sv
module test_bm_dma_regs;
  logic clk = 1'b0, rst = 1'b1;
  logic bus_wr = 0, bus_rd = 0;
  logic [2:0] bus_addr = '0;
  logic [3:0] bus_be = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, tbl_ptr;
  logic eng_busy = 0, eng_err_evt = 0, eng_int_evt = 0;
  logic start, dir_to_mem, irq, cpl_ok;
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  bm_dma_regs i_bm_dma_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .eng_busy(eng_busy), .eng_err_evt(eng_err_evt), .eng_int_evt(eng_int_evt),
    .start(start), .dir_to_mem(dir_to_mem), .irq(irq), .cpl_ok(cpl_ok), .tbl_ptr(tbl_ptr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [3:0] b, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_be = b; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 0; bus_be = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  task automatic pulse(input logic e, input logic i);
    @(negedge clk);
    eng_err_evt = e; eng_int_evt = i;
    @(posedge clk);
    @(negedge clk);
    eng_err_evt = 0; eng_int_evt = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, s, m;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    // R1 reset state
    rd(0, d); chk("R1 word0", d, 0);
    rd(4, d); chk("R1 ptr", d, 0);
    chk("R1 outs", {start, dir_to_mem, irq, cpl_ok}, 0);

    // R2 / R3 control byte sweep
    for (int v = 0; v < 256; v++) begin
      wr(0, 4'b0001, 0);
      wr(0, 4'b0001, v);
      chk("R2 start", start, v & 1);
      chk("R2 dir", dir_to_mem, (v >> 3) & 1);
      rd(0, d); chk("R11 ctl byte", d, v & 32'h09);
      if (v & 1) begin
        wr(0, 4'b0001, v ^ 8);
        chk("R3 dir locked", dir_to_mem, (v >> 3) & 1);
        chk("R3 start kept", start, 1);
      end
    end
    wr(0, 4'b0000, 32'hFFFF_FFFF);
    chk("R11 no-lane write", {start, dir_to_mem}, 2'b11);
    wr(0, 4'b0001, 0);

    // R5 / R6 / R7 / R8 / R9 status sweep
    for (int v = 0; v < 256; v++) begin
      pulse(1, 1);
      wr(0, 4'b0100, v << 16);
      rd(0, d);
      s = {v[6:5], 2'b00, ~v[2], ~v[1], 1'b0};
      chk("R6 R7 status", d[23:16], s);
      chk("R8 irq", irq, ~v[2] & 1'b1);
      chk("R9 cpl_ok", cpl_ok, ~v[2] & v[1] & 1'b1);
    end

    // R6 write-back of read value clears both flags, keeps capability bits
    wr(0, 4'b0100, 32'h0060_0000);
    pulse(1, 1);
    rd(0, d);
    chk("R5 both set", d[23:16], 8'h66);
    wr(0, 4'b0100, d);
    rd(0, d); chk("R6 writeback", d[23:16], 8'h60);
    // R6 event beats simultaneous clear
    @(negedge clk);
    bus_wr = 1; bus_addr = 0; bus_be = 4'b0100; bus_wdata = 32'h0064_0000; eng_int_evt = 1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 0; bus_be = 0; eng_int_evt = 0;
    chk("R6 event wins", irq, 1);
    chk("R9 clean done", cpl_ok, 1);

    // R4 busy tracking
    eng_busy = 1;
    wr(0, 4'b0001, 1);
    rd(0, d); chk("R4 act on", d[16], 1);
    chk("R9 busy blocks", cpl_ok, 0);
    @(negedge clk) eng_busy = 0;
    @(posedge clk); @(negedge clk);
    rd(0, d); chk("R4 act follows", d[16], 0);
    @(negedge clk) eng_busy = 1;
    @(posedge clk); @(negedge clk);
    rd(0, d); chk("R4 act back", d[16], 1);
    wr(0, 4'b0001, 0);
    rd(0, d); chk("R4 stop clears", d[16], 0);
    chk("R9 after stop", cpl_ok, 1);
    eng_busy = 0;
    pulse(1, 0);
    chk("R9 err blocks", cpl_ok, 0);

    // R10 pointer byte lanes
    for (int b = 0; b < 16; b++) begin
      wr(4, 4'hF, 0);
      wr(4, b[3:0], 32'hDEAD_BEEF);
      m = {{8{b[3]}}, {8{b[2]}}, {8{b[1]}}, {8{b[0]}}};
      chk("R10 tbl_ptr", tbl_ptr, 32'hDEAD_BEEF & m & 32'hFFFF_FFFC);
      rd(4, d); chk("R10 R11 ptr read", d, 32'hDEAD_BEEF & m & 32'hFFFF_FFFC);
    end
    rd(0, d); chk("R11 ptr write isolated", d[7:0], 0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule